// File: doc/BRIEF.md
# PWM Fault Protection Unit

This block guards the outputs of a multi-channel PWM generator. Six fault inputs are watched continuously. Each input is first synchronised to the block clock. It may then be filtered against short pulses and compared against its own programmed active level. A fault that is active forces the high-side and low-side outputs of every channel that has enabled it to programmed safe levels. Fault forcing takes priority over the values arriving from the output override stage upstream.

Each fault can run in one of two modes. In level-following mode it is active only while its input sits at the active level. In latched mode it stays active after the input returns to the inactive level, until software writes its clear bit. A clear written while the input is still active is discarded, so the fault then needs a fresh clear once the input has gone inactive.

Software reaches the block through simple write and read strobes. Through them it sets polarity, mode, filter enables, per-channel fault masks and forced values, and reads back fault status and input levels.

Top module: `pwm_fault_guard`

## Requirements
- R1: Any fault can force any channel. A channel is forced when at least one fault that is active is set in its 6-bit mask. The mask sits at address 5, bits [8c+5:8c] for channel c.
- R2: Polarity register (address 0, bit f): 1 means active-high and 0 means active-low. An unfiltered input that reaches its active level makes the fault active after the third rising clock edge.
- R3: In level-following mode (address 1, bit f = 0), an unfiltered fault becomes inactive after the third rising edge following the input's return to the inactive level.
- R4: In latched mode (address 1, bit f = 1), a fault stays active after its input goes inactive. It becomes inactive on the edge that takes a write of 1 to bit f at the clear address 3.
- R5: A clear write that arrives while the input is still at its active level has no effect. The fault then stays active after the input goes inactive, until a later clear is written.
- R6: With the filter enabled (address 2, bit f = 1), a pulse lasting one clock is rejected. A level held for two or more clocks is accepted, two clocks later than without the filter.
- R7: A forced channel c drives the high value from address 6 bit c and the low value from address 6 bit 8+c. An unforced channel passes its override-stage inputs through unchanged.
- R8: The status address 4 reads the active faults in bits [5:0] and the synchronised raw input levels in bits [13:8]. The `fault_active` port shows the same active bits.
- R9: After reset, polarity reads 0x3F (all active-high). Mode, filter, masks and forced values read 0, and no fault is active.
- R10: The configuration registers read back the values written to their implemented bits. The clear address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_in | input | 6 | Asynchronous fault inputs |
| ovr_hi | input | 4 | High-side values from the override stage, one per channel |
| ovr_lo | input | 4 | Low-side values from the override stage, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| pwm_hi | output | 4 | Protected high-side outputs |
| pwm_lo | output | 4 | Protected low-side outputs |
| fault_active | output | 6 | Active fault vector |

## Verification
The assertions are checked on every cycle, and each guards one local rule.
- A matching input always makes a fault active on the next edge.
- A latched fault does not drop without a clear.
- A clear is ignored while the input still matches.
- The filter only accepts a value that was stable for two samples.
- A forced channel always shows its programmed values.
- The status read agrees with the active port.

Some properties are end to end, and only the bench scenarios can show them. These are the exact three- and five-edge latencies from the pin to the output, the rejection of a one-clock pulse next to an unfiltered input that lets the same pulse through, and a latched fault surviving a clear that came too early. The bench also shows the mapping of masks onto channels and the register read-back.

// File: rtl/pwm_fault_pkg.sv
package pwm_fault_pkg;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] A_POL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
  localparam logic [ADDR_W-1:0] A_FILT = 3'd2;
  localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_MASK = 3'd5;
  localparam logic [ADDR_W-1:0] A_FVAL = 3'd6;

  // input level matches the programmed active level
  function automatic logic fault_hit(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction

  // channel forced when any enabled fault is active
  function automatic logic any_enabled(input logic [7:0] mask, input logic [7:0] act);
    return |(mask & act);
  endfunction

endpackage

// File: rtl/pfg_input.sv
module pfg_input (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic filt_en,
  output logic level_o,
  output logic cond_o
);
  logic s1_q, s2_q, s3_q, flt_q;
  logic stable_w;

  assign stable_w = (s2_q == s3_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      s1_q <= din;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (stable_w) flt_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign cond_o  = filt_en ? flt_q : s2_q;

  // R6: the filtered value only moves to a value seen on two successive samples
  p_filter_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flt_q) |-> ($past(s2_q) == flt_q && $past(s3_q) == flt_q));

endmodule

// File: rtl/pfg_latch.sv
module pfg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic latch_mode,
  input  logic clr,
  output logic active_o
);
  logic act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           act_q <= 1'b0;
    else if (hit)         act_q <= 1'b1;
    else if (!latch_mode) act_q <= 1'b0;
    else if (clr)         act_q <= 1'b0;
  end

  assign active_o = act_q;

  p_set_on_hit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> act_q);

  p_follow_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && !hit) |=> !act_q);

  p_latched_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && act_q && !clr) |=> act_q);

  p_early_clear_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && hit) |=> act_q);

endmodule

// File: rtl/pfg_regs.sv
module pfg_regs
  import pwm_fault_pkg::*;
#(
  parameter int unsigned N_FAULT = 6,
  parameter int unsigned N_CHAN  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [ADDR_W-1:0]               wr_addr,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic [ADDR_W-1:0]               rd_addr,
  output logic [DATA_W-1:0]               rd_data,
  input  logic [N_FAULT-1:0]              active_i,
  input  logic [N_FAULT-1:0]              level_i,
  output logic [N_FAULT-1:0]              pol_o,
  output logic [N_FAULT-1:0]              mode_o,
  output logic [N_FAULT-1:0]              filt_o,
  output logic [N_FAULT-1:0]              clr_o,
  output logic [N_CHAN-1:0][N_FAULT-1:0]  mask_o,
  output logic [N_CHAN-1:0]               fvh_o,
  output logic [N_CHAN-1:0]               fvl_o
);
  localparam int unsigned LANE = 8;

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_o  <= '1;
      mode_o <= '0;
      filt_o <= '0;
      mask_o <= '0;
      fvh_o  <= '0;
      fvl_o  <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_POL:  pol_o  <= wr_data[N_FAULT-1:0];
        A_MODE: mode_o <= wr_data[N_FAULT-1:0];
        A_FILT: filt_o <= wr_data[N_FAULT-1:0];
        A_MASK: for (int c = 0; c < N_CHAN; c++) mask_o[c] <= wr_data[LANE*c +: N_FAULT];
        A_FVAL: begin
          fvh_o <= wr_data[N_CHAN-1:0];
          fvl_o <= wr_data[LANE +: N_CHAN];
        end
        default: ;
      endcase
    end
  end

  // clear is a one-cycle pulse, never stored
  assign clr_o = (wr_en && wr_addr == A_CLR) ? wr_data[N_FAULT-1:0] : '0;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_POL:  rd_data[N_FAULT-1:0] = pol_o;
      A_MODE: rd_data[N_FAULT-1:0] = mode_o;
      A_FILT: rd_data[N_FAULT-1:0] = filt_o;
      A_STAT: begin
        rd_data[N_FAULT-1:0]     = active_i;
        rd_data[LANE +: N_FAULT] = level_i;
      end
      A_MASK: for (int c = 0; c < N_CHAN; c++) rd_data[LANE*c +: N_FAULT] = mask_o[c];
      A_FVAL: begin
        rd_data[N_CHAN-1:0]     = fvh_o;
        rd_data[LANE +: N_CHAN] = fvl_o;
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/pfg_chan.sv
module pfg_chan
  import pwm_fault_pkg::*;
#(
  parameter int unsigned N_FAULT = 6
) (
  input  logic [N_FAULT-1:0] mask,
  input  logic [N_FAULT-1:0] active,
  input  logic               fv_hi,
  input  logic               fv_lo,
  input  logic               ovr_hi,
  input  logic               ovr_lo,
  output logic               out_hi,
  output logic               out_lo,
  output logic               forced_o
);
  assign forced_o = any_enabled(8'(mask), 8'(active));
  assign out_hi   = forced_o ? fv_hi : ovr_hi;
  assign out_lo   = forced_o ? fv_lo : ovr_lo;
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard
  import pwm_fault_pkg::*;
#(
  parameter int unsigned N_FAULT = 6,   // at most 8: one byte lane per channel mask
  parameter int unsigned N_CHAN  = 4    // at most 4: four lanes in a data word
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_FAULT-1:0]   fault_in,
  input  logic [N_CHAN-1:0]    ovr_hi,
  input  logic [N_CHAN-1:0]    ovr_lo,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [DATA_W-1:0]    rd_data,
  output logic [N_CHAN-1:0]    pwm_hi,
  output logic [N_CHAN-1:0]    pwm_lo,
  output logic [N_FAULT-1:0]   fault_active
);
  logic [N_FAULT-1:0]             pol_w, mode_w, filt_w, clr_w;
  logic [N_FAULT-1:0]             level_w, cond_w, hit_w, act_w;
  logic [N_CHAN-1:0][N_FAULT-1:0] mask_w;
  logic [N_CHAN-1:0]              fvh_w, fvl_w, forced_w;

  pfg_regs #(.N_FAULT(N_FAULT), .N_CHAN(N_CHAN)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .active_i(act_w), .level_i(level_w),
    .pol_o(pol_w), .mode_o(mode_w), .filt_o(filt_w), .clr_o(clr_w),
    .mask_o(mask_w), .fvh_o(fvh_w), .fvl_o(fvl_w)
  );

  for (genvar f = 0; f < N_FAULT; f++) begin : g_fault
    pfg_input u_in (
      .clk(clk), .rst_n(rst_n), .din(fault_in[f]), .filt_en(filt_w[f]),
      .level_o(level_w[f]), .cond_o(cond_w[f])
    );

    assign hit_w[f] = fault_hit(cond_w[f], pol_w[f]);

    pfg_latch u_latch (
      .clk(clk), .rst_n(rst_n), .hit(hit_w[f]), .latch_mode(mode_w[f]),
      .clr(clr_w[f]), .active_o(act_w[f])
    );
  end

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    pfg_chan #(.N_FAULT(N_FAULT)) u_chan (
      .mask(mask_w[c]), .active(act_w),
      .fv_hi(fvh_w[c]), .fv_lo(fvl_w[c]),
      .ovr_hi(ovr_hi[c]), .ovr_lo(ovr_lo[c]),
      .out_hi(pwm_hi[c]), .out_lo(pwm_lo[c]), .forced_o(forced_w[c])
    );

    p_fault_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      forced_w[c] |-> (pwm_hi[c] == fvh_w[c] && pwm_lo[c] == fvl_w[c]));

    p_pass_through_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !forced_w[c] |-> (pwm_hi[c] == ovr_hi[c] && pwm_lo[c] == ovr_lo[c]));
  end

  assign fault_active = act_w;

  p_status_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == A_STAT) |-> (rd_data[N_FAULT-1:0] == fault_active));

endmodule

// File: tb/pwm_fault_guard_test.sv
`timescale 1ns/1ps
module pwm_fault_guard_test;
  localparam int NF = 6;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NF-1:0] fault_in = '0;
  logic [NC-1:0] ovr_hi = 4'b1010, ovr_lo = 4'b0101;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0, rd_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [31:0]   rd_data;
  logic [NC-1:0] pwm_hi, pwm_lo;
  logic [NF-1:0] fault_active;

  pwm_fault_guard uut (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .ovr_hi(ovr_hi), .ovr_lo(ovr_lo),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo), .fault_active(fault_active)
  );

  always #4 clk = ~clk;

  typedef struct {
    string       tag;
    int          kind;   // 0: outputs {lo,hi}, 1: read data
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench-side model state
  logic [NF-1:0] m_mask [NC];
  logic [NC-1:0] m_fvh = '0, m_fvl = '0;
  logic [NF-1:0] m_act = '0;

  function automatic logic [7:0] model_out();
    logic [NC-1:0] h, l;
    for (int c = 0; c < NC; c++) begin
      logic hitc;
      hitc = (m_mask[c] & m_act) != '0;
      h[c] = hitc ? m_fvh[c] : ovr_hi[c];
      l[c] = hitc ? m_fvl[c] : ovr_lo[c];
    end
    return {l, h};
  endfunction

  // monitor: pops expected items and compares with the design
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (q.size() != 0);
      it = q.pop_front();
      act = (it.kind == 0) ? {24'd0, pwm_lo, pwm_hi} : rd_data;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic push(string tag, int kind, logic [31:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
    #1;
  endtask

  task automatic check_out(string tag);
    #1;
    push(tag, 0, {24'd0, model_out()});
  endtask

  task automatic check_rd(string tag, logic [2:0] a, logic [31:0] exp);
    rd_addr = a;
    #1;
    push(tag, 1, exp);
  endtask

  function automatic logic [31:0] status_exp();
    return {18'd0, fault_in, 2'b00, m_act};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NC; c++) m_mask[c] = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R9: reset state
    check_rd("R9 polarity reset", 3'd0, 32'h3F);
    check_rd("R9 mode reset", 3'd1, 32'h0);
    check_rd("R9 mask reset", 3'd5, 32'h0);
    check_rd("R9 status reset", 3'd4, status_exp());
    check_out("R9 outputs pass after reset");

    // configure masks and forced values
    wr(3'd5, 32'h20_0C_02_01);
    m_mask[0] = 6'h01; m_mask[1] = 6'h02; m_mask[2] = 6'h0C; m_mask[3] = 6'h20;
    wr(3'd6, 32'h0000_0A05);
    m_fvh = 4'b0101; m_fvl = 4'b1010;
    check_rd("R10 mask readback", 3'd5, 32'h20_0C_02_01);
    check_rd("R10 fval readback", 3'd6, 32'h0A05);
    check_out("R7 unforced pass-through");

    // R2/R3: fault0 active-high, level mode
    @(negedge clk); fault_in[0] = 1'b1;
    step(2);
    check_rd("R8 level visible before active", 3'd4, 32'h100);
    check_out("R2 not yet forced after two edges");
    step(1); m_act = 6'h01;
    check_out("R2 forced after third edge");
    check_rd("R8 status fault0", 3'd4, status_exp());
    fault_in[0] = 1'b0;
    step(2);
    check_out("R3 still forced two edges after release");
    step(1); m_act = 6'h00;
    check_out("R3 released after third edge");

    // R2: active-low polarity on fault1
    wr(3'd0, 32'h3D);
    step(2); m_act = 6'h02;
    check_out("R2 active-low fault1 forces ch1");
    fault_in[1] = 1'b1;
    step(3); m_act = 6'h00;
    check_out("R2 active-low fault1 released");

    // R4: latched fault2
    wr(3'd1, 32'h04);
    @(negedge clk); fault_in[2] = 1'b1;
    step(3); m_act = 6'h04;
    check_rd("R4 latched fault2 active", 3'd4, status_exp());
    fault_in[2] = 1'b0;
    step(5);
    check_out("R4 latched holds after input drop");
    check_rd("R4 latched status held", 3'd4, status_exp());
    wr(3'd3, 32'h04); m_act = 6'h00;
    check_out("R4 cleared by write");
    check_rd("R4 status after clear", 3'd4, status_exp());
    check_rd("R10 clear reads zero", 3'd3, 32'h0);

    // R5: early clear ignored on fault3
    wr(3'd1, 32'h0C);
    @(negedge clk); fault_in[3] = 1'b1;
    step(3); m_act = 6'h08;
    wr(3'd3, 32'h08);
    check_rd("R5 early clear ignored", 3'd4, status_exp());
    fault_in[3] = 1'b0;
    step(5);
    check_out("R5 still latched after input drop");
    wr(3'd3, 32'h08); m_act = 6'h00;
    check_out("R5 second clear releases");

    // R6: filter on fault5, unfiltered fault4 as contrast
    wr(3'd2, 32'h20);
    check_rd("R10 filter readback", 3'd2, 32'h20);
    @(negedge clk); fault_in[5:4] = 2'b11;
    @(negedge clk); fault_in[5:4] = 2'b00;
    step(2); m_act = 6'h10;
    check_rd("R6 one-cycle pulse: unfiltered seen, filtered rejected", 3'd4, status_exp());
    check_out("R6 ch3 not forced by rejected pulse");
    step(3); m_act = 6'h00;
    check_rd("R6 no late acceptance", 3'd4, status_exp());
    @(negedge clk); fault_in[5] = 1'b1;
    step(2); fault_in[5] = 1'b0;
    step(2);
    check_out("R6 two-cycle pulse not yet accepted at edge four");
    step(1); m_act = 6'h20;
    check_out("R6 two-cycle pulse accepted at edge five");
    step(2); m_act = 6'h00;
    check_out("R6 filtered release");

    // R1: remap masks, fault4 on several channels
    wr(3'd5, 32'h30_10_00_10);
    m_mask[0] = 6'h10; m_mask[1] = 6'h00; m_mask[2] = 6'h10; m_mask[3] = 6'h30;
    @(negedge clk); fault_in[4] = 1'b1;
    step(3); m_act = 6'h10;
    check_out("R1 fault4 forces ch0 ch2 ch3 only");

    // R7: override changes pass only on unforced channel
    ovr_hi = 4'b0110; ovr_lo = 4'b1001;
    check_out("R7 forced wins, ch1 follows new override");
    fault_in[4] = 1'b0;
    step(3); m_act = 6'h00;
    check_out("R7 all channels follow override after release");

    step(2);
    wait (q.size() == 0);
    #1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule